// File: doc/BRIEF.md
# Dual-Clock FIFO Controller with Programmable Almost Flags

This block turns a simple dual-port memory array into a first-in first-out queue whose producer and consumer run on unrelated clocks. In queue mode it owns the array addresses: a write-side pointer advances on each accepted write, and a read-side pointer advances on each accepted read. Each pointer crosses into the other clock domain as Gray code through a two-stage synchroniser. The write side raises a full flag and an almost-full flag. The read side raises an empty flag and an almost-empty flag. Both almost thresholds are programmable.

A single mode input picks what drives the array. In queue mode the internal pointers address it. In direct mode the caller's own write and read addresses reach the array unchanged, the enables act directly, and the queue pointers and flags hold their values. A write offered while full and a read offered while empty are dropped without notice, so the stored data and the pointers stay intact. The flags err on the safe side. Because they are based on the other domain's delayed pointer, full and empty can clear a few cycles late, but they never assert late. The mode input is treated as quasi-static and changes only while both sides are idle.

Top module: `dcfifo_ctrl`

## Requirements
- R1: After a synchronous reset of both domains, empty and aempty read 1 and full and afull read 0.
- R2: In queue mode (fifo_mode=1), words leave in the order they were accepted. The word for a read sampled on a rising rd_clk edge appears on rd_data just after that same edge.
- R3: full reads 1 once DEPTH (16) words are held. A write offered while full is dropped and does not disturb stored data or later ordering.
- R4: empty reads 1 when no word is held. A read offered while empty is dropped and rd_data keeps its previous value.
- R5: afull reads 1 exactly when the write side's view of the occupancy is greater than or equal to afull_level.
- R6: aempty reads 1 exactly when the read side's view of the occupancy is less than or equal to aempty_level.
- R7: In direct mode (fifo_mode=0), wr_en writes wr_data at ext_wr_addr, and rd_en loads rd_data from ext_rd_addr on the next rd_clk edge. The queue pointers and flags do not change.
- R8: Each pointer's Gray-coded copy changes in at most one bit per clock of its own domain.
- R9: The occupancy seen by either side never exceeds DEPTH and never goes negative. A pointer does not advance while its blocking flag (full or empty) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write word |
| ext_wr_addr | input | ADDR_W | Write address used in direct mode |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| ext_rd_addr | input | ADDR_W | Read address used in direct mode |
| rd_data | output | DATA_W | Registered read word |
| fifo_mode | input | 1 | 1 = queue addressing, 0 = direct addressing |
| afull_level | input | ADDR_W+1 | Almost-full occupancy threshold |
| aempty_level | input | ADDR_W+1 | Almost-empty occupancy threshold |
| full | output | 1 | Queue full (write domain) |
| afull | output | 1 | Occupancy at or above afull_level (write domain) |
| empty | output | 1 | Queue empty (read domain) |
| aempty | output | 1 | Occupancy at or below aempty_level (read domain) |

## Verification
The embedded properties check, on every clock, the rules that do not depend on timing. Each Gray pointer changes in at most one bit per clock. Neither side ever sees more than DEPTH words. No pointer moves while its blocking flag is set or while the block is in direct mode. Reset leaves the flags in their idle state. Data order, the drop of overflowing writes and of underflowing reads, the exact almost-flag thresholds and direct-mode addressing can only be shown by the bench's scenarios. Those scenarios run a reference queue and let both domains settle before each flag is compared.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    typedef enum logic {
        SRC_EXTERNAL = 1'b0,
        SRC_QUEUE    = 1'b1
    } addr_src_e;

    localparam int CODE_MAX_W = 16;

    typedef struct packed {
        logic full;
        logic afull;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic aempty;
    } rd_flags_t;

    function automatic logic [CODE_MAX_W-1:0] to_gray(input logic [CODE_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CODE_MAX_W-1:0] from_gray(input logic [CODE_MAX_W-1:0] g);
        logic [CODE_MAX_W-1:0] b;
        b[CODE_MAX_W-1] = g[CODE_MAX_W-1];
        for (int i = CODE_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_ptr_sync.sv
module dcfifo_ptr_sync
    import dcfifo_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stage1_q;
    logic [PW-1:0] stage2_q;
    logic [CODE_MAX_W-1:0] wide_bin;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    always_comb begin
        wide_bin = from_gray(CODE_MAX_W'(stage2_q));
        bin_out  = wide_bin[PW-1:0];
    end

endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  addr_src_e       src,
    input  logic            wr_en,
    input  logic [ADDR_W:0] level,
    input  logic [ADDR_W:0] rd_ptr_seen,
    output logic [ADDR_W:0] ptr_bin,
    output logic [ADDR_W:0] ptr_gray,
    output logic            fire,
    output wr_flags_t       flags
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0]          ptr_nxt;
    logic [PW-1:0]          occ_nxt;
    logic [CODE_MAX_W-1:0]  gray_wide;

    always_comb begin
        fire      = wr_en && (src == SRC_QUEUE) && !flags.full;
        ptr_nxt   = ptr_bin + PW'(fire);
        occ_nxt   = ptr_nxt - rd_ptr_seen;
        gray_wide = to_gray(CODE_MAX_W'(ptr_nxt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_bin     <= '0;
            ptr_gray    <= '0;
            flags.full  <= 1'b0;
            flags.afull <= 1'b0;
        end else begin
            ptr_bin     <= ptr_nxt;
            ptr_gray    <= gray_wide[PW-1:0];
            flags.full  <= (occ_nxt == PW'(DEPTH));
            flags.afull <= (occ_nxt >= level);
        end
    end

    // R8
    wr_gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ptr_gray ^ $past(ptr_gray)) <= 1);

    // R9
    wr_occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_bin - rd_ptr_seen) <= PW'(DEPTH));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.full && wr_en) |=> $stable(ptr_bin));

    // R7
    wr_direct_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_EXTERNAL) |=> $stable(ptr_bin));

    // R1
    wr_reset_flags_chk: assert property (@(posedge clk)
        rst |=> (!flags.full && !flags.afull));

endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  addr_src_e       src,
    input  logic            rd_en,
    input  logic [ADDR_W:0] level,
    input  logic [ADDR_W:0] wr_ptr_seen,
    output logic [ADDR_W:0] ptr_bin,
    output logic [ADDR_W:0] ptr_gray,
    output logic            fire,
    output rd_flags_t       flags
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0]          ptr_nxt;
    logic [PW-1:0]          occ_nxt;
    logic [CODE_MAX_W-1:0]  gray_wide;

    always_comb begin
        fire      = rd_en && (src == SRC_QUEUE) && !flags.empty;
        ptr_nxt   = ptr_bin + PW'(fire);
        occ_nxt   = wr_ptr_seen - ptr_nxt;
        gray_wide = to_gray(CODE_MAX_W'(ptr_nxt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_bin      <= '0;
            ptr_gray     <= '0;
            flags.empty  <= 1'b1;
            flags.aempty <= 1'b1;
        end else begin
            ptr_bin      <= ptr_nxt;
            ptr_gray     <= gray_wide[PW-1:0];
            flags.empty  <= (occ_nxt == '0);
            flags.aempty <= (occ_nxt <= level);
        end
    end

    // R8
    rd_gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ptr_gray ^ $past(ptr_gray)) <= 1);

    // R9
    rd_occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr_seen - ptr_bin) <= PW'(DEPTH));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && rd_en) |=> $stable(ptr_bin));

    // R7
    rd_direct_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_EXTERNAL) |=> $stable(ptr_bin));

    // R1
    rd_reset_flags_chk: assert property (@(posedge clk)
        rst |=> (flags.empty && flags.aempty));

endmodule

// File: rtl/dcfifo_dp_ram.sv
module dcfifo_dp_ram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl
    import dcfifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ext_wr_addr,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ext_rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fifo_mode,
    input  logic [ADDR_W:0]   afull_level,
    input  logic [ADDR_W:0]   aempty_level,
    output logic              full,
    output logic              afull,
    output logic              empty,
    output logic              aempty
);
    localparam int PW = ADDR_W + 1;

    addr_src_e     src;
    logic [PW-1:0] wptr_bin, wptr_gray, wptr_seen_rd;
    logic [PW-1:0] rptr_bin, rptr_gray, rptr_seen_wr;
    logic          wr_fire, rd_fire;
    wr_flags_t     wflags;
    rd_flags_t     rflags;

    logic              ram_we, ram_re;
    logic [ADDR_W-1:0] ram_waddr, ram_raddr;

    assign src = addr_src_e'(fifo_mode);

    dcfifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .src(src), .wr_en(wr_en),
        .level(afull_level), .rd_ptr_seen(rptr_seen_wr),
        .ptr_bin(wptr_bin), .ptr_gray(wptr_gray), .fire(wr_fire), .flags(wflags)
    );

    dcfifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .src(src), .rd_en(rd_en),
        .level(aempty_level), .wr_ptr_seen(wptr_seen_rd),
        .ptr_bin(rptr_bin), .ptr_gray(rptr_gray), .fire(rd_fire), .flags(rflags)
    );

    dcfifo_ptr_sync #(.PW(PW)) u_sync_r2w (
        .clk(wr_clk), .rst(wr_rst), .gray_in(rptr_gray), .bin_out(rptr_seen_wr)
    );

    dcfifo_ptr_sync #(.PW(PW)) u_sync_w2r (
        .clk(rd_clk), .rst(rd_rst), .gray_in(wptr_gray), .bin_out(wptr_seen_rd)
    );

    always_comb begin
        if (src == SRC_QUEUE) begin
            ram_we    = wr_fire;
            ram_waddr = wptr_bin[ADDR_W-1:0];
            ram_re    = rd_fire;
            ram_raddr = rptr_bin[ADDR_W-1:0];
        end else begin
            ram_we    = wr_en;
            ram_waddr = ext_wr_addr;
            ram_re    = rd_en;
            ram_raddr = ext_rd_addr;
        end
    end

    dcfifo_dp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk(wr_clk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
        .rclk(rd_clk), .re(ram_re), .raddr(ram_raddr), .rdata(rd_data)
    );

    assign full   = wflags.full;
    assign afull  = wflags.afull;
    assign empty  = rflags.empty;
    assign aempty = rflags.aempty;

endmodule

// File: tb/dcfifo_ctrl_test.sv
module dcfifo_ctrl_test;
    localparam int DATA_W = 9;
    localparam int ADDR_W = 4;

    logic              wr_clk = 0, rd_clk = 0;
    logic              wr_rst, rd_rst, wr_en, rd_en, fifo_mode;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [ADDR_W-1:0] ext_wr_addr, ext_rd_addr;
    logic [ADDR_W:0]   afull_level, aempty_level;
    logic              full, afull, empty, aempty;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] model[$];
    logic [DATA_W-1:0] next_val = 9'h010;
    logic [DATA_W-1:0] got, held;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    dcfifo_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .ext_wr_addr(ext_wr_addr), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .ext_rd_addr(ext_rd_addr), .rd_data(rd_data), .fifo_mode(fifo_mode),
        .afull_level(afull_level), .aempty_level(aempty_level),
        .full(full), .afull(afull), .empty(empty), .aempty(aempty)
    );

    // {writes, reads, full, empty, afull, aempty}; afull_level=12, aempty_level=3
    localparam logic [19:0] VEC [6] = '{
        {8'd5, 8'd0,  4'b0000},
        {8'd7, 8'd0,  4'b0010},
        {8'd4, 8'd0,  4'b1010},
        {8'd0, 8'd13, 4'b0001},
        {8'd0, 8'd3,  4'b0101},
        {8'd2, 8'd0,  4'b0001}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DATA_W-1:0] d, input logic track);
        @(negedge wr_clk);
        wr_en = 1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 0;
        if (track) model.push_back(d);
    endtask

    task automatic pop(output logic [DATA_W-1:0] d);
        @(negedge rd_clk);
        rd_en = 1;
        @(posedge rd_clk);
        #1 d = rd_data;
        @(negedge rd_clk);
        rd_en = 0;
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
        #1;
    endtask

    task automatic check_flags(input logic [3:0] exp, input string tag);
        chk(full == exp[3], {tag, " R3 full"}, full, exp[3]);
        chk(empty == exp[2], {tag, " R4 empty"}, empty, exp[2]);
        chk(afull == exp[1], {tag, " R5 afull"}, afull, exp[1]);
        chk(aempty == exp[0], {tag, " R6 aempty"}, aempty, exp[0]);
    endtask

    task automatic do_reset();
        wr_rst = 1; rd_rst = 1;
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
        wr_rst = 0; rd_rst = 0;
        model.delete();
        settle();
    endtask

    initial begin
        #2ms;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wr_en = 0; rd_en = 0; fifo_mode = 1; wr_data = '0;
        ext_wr_addr = '0; ext_rd_addr = '0;
        afull_level = 5'd12; aempty_level = 5'd3;
        do_reset();
        check_flags(4'b0101, "R1 reset");

        // R2 R5 R6 table walk
        foreach (VEC[i]) begin
            for (int w = 0; w < int'(VEC[i][19:12]); w++) begin
                push(next_val, 1);
                next_val++;
            end
            if (VEC[i][19:12] != 0) settle();
            for (int r = 0; r < int'(VEC[i][11:4]); r++) begin
                pop(got);
                chk(got == model[0], "R2 order", got, model[0]);
                void'(model.pop_front());
            end
            settle();
            check_flags(VEC[i][3:0], "table");
        end

        // R3 overflow: fill, offer extras, confirm order intact
        for (int w = 0; w < 14; w++) begin
            push(next_val, 1);
            next_val++;
        end
        settle();
        check_flags(4'b1010, "fill");
        for (int w = 0; w < 3; w++) push(9'h1AA, 0);
        settle();
        chk(full == 1, "R3 still full", full, 1);
        for (int r = 0; r < 16; r++) begin
            pop(got);
            chk(got == model[0], "R3 no overwrite", got, model[0]);
            void'(model.pop_front());
        end
        settle();
        check_flags(4'b0101, "drained");

        // R4 underflow: rd_data holds, later order intact
        held = rd_data;
        pop(got);
        chk(got == held, "R4 hold", got, held);
        settle();
        chk(empty == 1, "R4 empty kept", empty, 1);
        push(9'h055, 1);
        settle();
        chk(empty == 0, "R4 empty clears", empty, 0);
        pop(got);
        chk(got == 9'h055, "R4 pointer intact", got, 9'h055);
        void'(model.pop_front());
        settle();

        // R7 direct addressing
        fifo_mode = 0;
        ext_wr_addr = 4'd3; push(9'h123, 0);
        ext_wr_addr = 4'd9; push(9'h0F0, 0);
        ext_rd_addr = 4'd9; pop(got);
        chk(got == 9'h0F0, "R7 direct rd 9", got, 9'h0F0);
        ext_rd_addr = 4'd3; pop(got);
        chk(got == 9'h123, "R7 direct rd 3", got, 9'h123);
        settle();
        check_flags(4'b0101, "R7 flags held");
        fifo_mode = 1;
        settle();
        push(9'h0AB, 1);
        settle();
        pop(got);
        chk(got == 9'h0AB, "R7 queue resumes", got, 9'h0AB);
        void'(model.pop_front());

        // R5 R6 thresholds moved
        afull_level = 5'd2; aempty_level = 5'd0;
        push(9'h001, 1); push(9'h002, 1);
        settle();
        check_flags(4'b0010, "R5 R6 new levels");

        // R1 reset while holding data
        do_reset();
        check_flags(4'b0101, "R1 mid reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule